// File: doc/BRIEF.md
# BCD Seven-Segment Latch, Decoder and Phase Driver

This block turns a four-bit decimal digit into the seven segment lines a to g of a numeric display. The digit passes through a storage register that loads on every clock edge while the load enable is high and keeps its value while the enable is low. The stored digit is decoded into a segment pattern. Codes above nine light nothing, and a blank input turns every segment off at once.

A phase input is XORed onto every segment line after decoding and blanking. A steady low phase suits common-cathode LEDs and a steady high phase suits common-anode LEDs. For a liquid-crystal panel, a square wave on the phase input makes lit segments swing against the backplane while unlit segments follow it. A backplane output repeats the phase input for the panel's common electrode. Blanking and phase act without a clock delay. Only the digit store is clocked.

Top module: `bcd_seg_latch_driver`

## Requirements
- R1: A synchronous active-high reset puts an illegal code in the store, so from the first cycle after reset until the first load every segment output equals phaseIn.
- R2: While latchEn is 1, each rising clock edge loads digitIn, and the segments show the new digit right after that edge.
- R3: While latchEn is 0, the stored digit holds and changes on digitIn have no effect on segOut.
- R4: Before phase inversion, segOut[6:0] holds segments a..g with a in bit 6. Codes 0 to 9 give 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111, 1111011.
- R5: Stored codes 10 to 15 give 0000000 before phase inversion.
- R6: While blankIn is 1, segOut equals the off pattern XOR phase, with no clock delay and whatever latchEn and digitIn are. The store still loads during blanking.
- R7: Every segment output is the decoded value XOR phaseIn. A change on phaseIn reaches segOut in the same cycle.
- R8: backplane always equals phaseIn, so a lit segment is the complement of backplane and an unlit one equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the digit store |
| rst | input | 1 | Synchronous active-high reset |
| digitIn | input | 4 | BCD digit to load |
| latchEn | input | 1 | 1: store loads each edge; 0: store holds |
| blankIn | input | 1 | 1: all segments off |
| phaseIn | input | 1 | Output inversion / LCD drive phase |
| segOut | output | 7 | Segments a (bit 6) to g (bit 0) |
| backplane | output | 1 | Common-electrode drive, equal to phaseIn |

## Verification
The bench loads all sixteen codes under each combination of blank and phase. A wrong table entry, a code above nine that lights something, or a blanked pattern that ignores inversion shows up as a wrong segment word. It lowers the load enable, moves the digit input and clocks several times, which catches a store that stays transparent. Blanking inside a hold and then releasing it catches a design that clears the store on blank. Phase is toggled between clock edges, which catches a design that registers phase, and a square-wave phase run checks lit and unlit segments against the backplane.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  parameter int DIGIT_W = 4;
  parameter int SEG_N   = 7;
  localparam int MAX_LEGAL = 9;

  typedef struct packed {
    logic clearStore;
    logic loadStore;
    logic forceOff;
    logic invert;
  } segStrobes_t;
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic        rst,
  input  logic        latchEn,
  input  logic        blankIn,
  input  logic        phaseIn,
  output segStrobes_t strobes
);
  always_comb begin
    strobes.clearStore = rst;
    strobes.loadStore  = latchEn & ~rst;
    strobes.forceOff   = blankIn;
    strobes.invert     = phaseIn;
  end
endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
#(
  parameter int DW = DIGIT_W,
  parameter int SN = SEG_N,
  parameter logic [DW-1:0] RESET_CODE = '1
) (
  input  logic          clk,
  input  segStrobes_t   strobes,
  input  logic [DW-1:0] digitIn,
  output logic [SN-1:0] segOut
);
  logic [DW-1:0] storedDigit;
  logic [SN-1:0] rawPattern;
  logic [SN-1:0] gatedPattern;

  always_ff @(posedge clk) begin
    if (strobes.clearStore)
      storedDigit <= RESET_CODE;
    else if (strobes.loadStore)
      storedDigit <= digitIn;
  end

  // bit SN-1 is segment a, bit 0 is segment g
  always_comb begin
    rawPattern = '0;
    if (storedDigit <= DW'(MAX_LEGAL)) begin
      case (storedDigit[3:0])
        4'd0: rawPattern = SN'(7'b1111110);
        4'd1: rawPattern = SN'(7'b0110000);
        4'd2: rawPattern = SN'(7'b1101101);
        4'd3: rawPattern = SN'(7'b1111001);
        4'd4: rawPattern = SN'(7'b0110011);
        4'd5: rawPattern = SN'(7'b1011011);
        4'd6: rawPattern = SN'(7'b1011111);
        4'd7: rawPattern = SN'(7'b1110000);
        4'd8: rawPattern = SN'(7'b1111111);
        4'd9: rawPattern = SN'(7'b1111011);
        default: rawPattern = '0;
      endcase
    end
  end

  assign gatedPattern = strobes.forceOff ? '0 : rawPattern;

  for (genvar s = 0; s < SN; s++) begin : g_phase
    assign segOut[s] = gatedPattern[s] ^ strobes.invert;
  end
endmodule

// File: rtl/bcd_seg_latch_driver.sv
module bcd_seg_latch_driver
  import segdec_pkg::*;
#(
  parameter int DW = DIGIT_W,
  parameter int SN = SEG_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] digitIn,
  input  logic          latchEn,
  input  logic          blankIn,
  input  logic          phaseIn,
  output logic [SN-1:0] segOut,
  output logic          backplane
);
  segStrobes_t strobes;

  segdec_ctrl u_ctrl (
    .rst     (rst),
    .latchEn (latchEn),
    .blankIn (blankIn),
    .phaseIn (phaseIn),
    .strobes (strobes)
  );

  segdec_datapath #(.DW(DW), .SN(SN)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .digitIn (digitIn),
    .segOut  (segOut)
  );

  assign backplane = phaseIn;
endmodule

// File: rtl/bcd_seg_checker.sv
module bcd_seg_checker #(
  parameter int DW = 4,
  parameter int SN = 7
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] digitIn,
  input logic          latchEn,
  input logic          blankIn,
  input logic          phaseIn,
  input logic [SN-1:0] segOut,
  input logic          backplane
);
  // R1: store shows blank right after reset
  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (latchEn || rst || segOut == {SN{phaseIn}}));

  // R3: with load disabled and blank/phase steady, outputs stay put
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !latchEn |=> (blankIn || $past(blankIn) || phaseIn != $past(phaseIn) || $stable(segOut)));

  // R4: a loaded decimal code lights at least two segments
  p_legal_lit_r4: assert property (@(posedge clk) disable iff (rst)
    (latchEn && digitIn <= DW'(9)) |=> (blankIn || $countones(segOut ^ {SN{phaseIn}}) >= 2));

  // R5: a loaded non-decimal code lights nothing
  p_illegal_off_r5: assert property (@(posedge clk) disable iff (rst)
    (latchEn && digitIn > DW'(9)) |=> (segOut == {SN{phaseIn}}));

  // R6: blanking overrides the store
  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    blankIn |-> (segOut == {SN{phaseIn}}));

  // R8: unlit segments follow the backplane when blanked
  p_backplane_r8: assert property (@(posedge clk) disable iff (rst)
    blankIn |-> ((segOut ^ {SN{backplane}}) == '0));
endmodule

bind bcd_seg_latch_driver bcd_seg_checker #(.DW(DW), .SN(SN)) u_chk (
  .clk(clk), .rst(rst), .digitIn(digitIn), .latchEn(latchEn),
  .blankIn(blankIn), .phaseIn(phaseIn), .segOut(segOut), .backplane(backplane)
);

// File: tb/sim_bcd_seg_latch_driver.sv
`timescale 1ns/1ps
module sim_bcd_seg_latch_driver;
  logic       clk = 0;
  logic       rst = 1;
  logic [3:0] digitIn = 0;
  logic       latchEn = 0;
  logic       blankIn = 0;
  logic       phaseIn = 0;
  logic [6:0] segOut;
  logic       backplane;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcd_seg_latch_driver u0 (
    .clk(clk), .rst(rst), .digitIn(digitIn), .latchEn(latchEn),
    .blankIn(blankIn), .phaseIn(phaseIn), .segOut(segOut), .backplane(backplane)
  );

  function automatic logic [6:0] expPattern(input int code);
    case (code)
      0: return 7'b1111110;
      1: return 7'b0110000;
      2: return 7'b1101101;
      3: return 7'b1111001;
      4: return 7'b0110011;
      5: return 7'b1011011;
      6: return 7'b1011111;
      7: return 7'b1110000;
      8: return 7'b1111111;
      9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [6:0] expOut(input int code, input logic blk, input logic ph);
    logic [6:0] p;
    p = blk ? 7'b0 : expPattern(code);
    return p ^ {7{ph}};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic loadDigit(input int code);
    @(negedge clk);
    digitIn = code[3:0];
    latchEn = 1;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset with latchEn low
    rst = 1; latchEn = 0; phaseIn = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    #2;
    check("R1 blank after reset ph0", segOut, 7'b0000000);
    phaseIn = 1; #2;
    check("R1 blank after reset ph1", segOut, 7'b1111111);
    phaseIn = 0;

    // R2/R4/R5/R6/R7/R8: full sweep
    for (int ph = 0; ph < 2; ph++) begin
      for (int bk = 0; bk < 2; bk++) begin
        for (int code = 0; code < 16; code++) begin
          @(negedge clk);
          phaseIn = ph[0];
          blankIn = bk[0];
          loadDigit(code);
          if (bk == 1) check("R6 blank sweep", segOut, expOut(code, 1'b1, ph[0]));
          else if (code > 9) check("R5 illegal sweep", segOut, expOut(code, 1'b0, ph[0]));
          else if (ph == 1) check("R7 inverted sweep", segOut, expOut(code, 1'b0, 1'b1));
          else check("R4 R2 decode sweep", segOut, expOut(code, 1'b0, 1'b0));
          check("R8 backplane", {6'b0, backplane}, {6'b0, phaseIn});
        end
      end
    end
    blankIn = 0; phaseIn = 0;

    // R3: hold while digit input moves
    loadDigit(5);
    @(negedge clk); latchEn = 0; digitIn = 8;
    repeat (3) @(posedge clk);
    #5;
    check("R3 hold digit 5", segOut, expOut(5, 0, 0));
    @(negedge clk); digitIn = 12;
    @(posedge clk); #5;
    check("R3 hold against illegal input", segOut, expOut(5, 0, 0));

    // R6: blank during hold, store intact afterwards
    @(negedge clk); blankIn = 1; #2;
    check("R6 blank immediate", segOut, 7'b0000000);
    @(posedge clk); #5;
    @(negedge clk); blankIn = 0; #2;
    check("R6 store kept under blank", segOut, expOut(5, 0, 0));

    // R6: store loads while blanked
    @(negedge clk); blankIn = 1;
    loadDigit(3);
    @(negedge clk); latchEn = 0; blankIn = 0; #2;
    check("R6 load during blank", segOut, expOut(3, 0, 0));

    // R7: phase change between edges reaches output at once
    @(posedge clk); #3;
    phaseIn = 1; #2;
    check("R7 phase no clock delay", segOut, expOut(3, 0, 1));
    phaseIn = 0; #2;
    check("R7 phase back", segOut, expOut(3, 0, 0));

    // R8: square-wave phase, lit vs backplane
    loadDigit(7);
    @(negedge clk); latchEn = 0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk); phaseIn = t[0]; #2;
      check("R8 lit opposes backplane", segOut ^ {7{backplane}}, expPattern(7));
    end
    phaseIn = 0;

    // R1: reset mid-run returns to blank
    @(negedge clk); rst = 1;
    @(posedge clk); #5;
    @(negedge clk); rst = 0; #2;
    check("R1 blank after second reset", segOut, 7'b0000000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule